// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small 16-bit accumulator-free load/store processor. A 6-bit micro-program counter selects one word of a constant control store. Every word carries the full set of datapath controls for one clock cycle (register loads, bus drivers, multiplexer selects, ALU function, memory enable and write strobe) together with a sequencing mode and a target micro-address. The sequencer therefore follows the table rather than hand-written decode logic. Only three situations make it look at its inputs: the opcode dispatch at the end of instruction fetch, the branch condition test and the choice between the two subroutine-call forms.

The surrounding datapath feeds the block the instruction register's opcode field (bits 15:12), the register/immediate select bit (bit 5), the three-bit field at bits 11:9 and the negative/zero/positive condition flags. Memory is assumed to answer in a single cycle, so no micro-state waits. The fetch sequence takes three cycles and runs before every instruction. Each execute sequence then takes one to five cycles. A halt opcode parks the sequencer in a state that repeats forever. A non-standard load forms its address as the sum of two registers, reads memory and writes the result back with the condition flags.

Top module: `useq_ctrl`

## Requirements
- R1: While rst_n is low every control output is 0. The first cycle after rst_n rises is the first fetch cycle.
- R2: Fetch takes three cycles. The first drives the PC onto the bus, loads the MAR and loads the PC with pc_sel=00 (increment). The second asserts mem_en with mem_we=0 and loads the MDR. The third drives the MDR onto the bus and loads the instruction register. ld_ir is asserted in no other cycle.
- R3: After fetch the next cycle is the first micro-state chosen by the opcode: 0001 add, 0101 and, 1001 not, 1110 lea, 1100 jmp, 0000 branch, 0010 ld, 0011 st, 0110 ldr, 0111 str, 1010 ldi, 1011 sti, 0100 call, 1101 summed load, 1111 halt. Opcode 1000 executes nothing and goes straight back to fetch. At most one bus driver is active in any cycle.
- R4: Add, and and not each take one cycle. In that cycle gate_alu, ld_reg and ld_cc are high and sr1_sel=1. alu_op is 00 for add, 01 for and and 10 for not. sr2_sel equals ir_imm_sel for add and and, and is 0 in every other cycle.
- R5: A branch spends one decision cycle with all controls 0. It is taken when (ir_cond[2]&cc_n)|(ir_cond[1]&cc_z)|(ir_cond[0]&cc_p). A taken branch adds one cycle with ld_pc, pc_sel=01, addr1_sel=0 and addr2_sel=10. A branch that is not taken returns to fetch.
- R6: ld and st form the address PC+offset9 (addr2_sel=10, mar_sel=1, gate_marmux, ld_mar). ldr and str form it as base+offset6 (sr1_sel=1, addr1_sel=1, addr2_sel=01). A read cycle has mem_en=1 and mem_we=0 and loads the MDR. A store first loads the MDR from the ALU with alu_op=11 and sr1_sel=0, then writes with mem_en=1 and mem_we=1.
- R7: ldi and sti read the pointer word and then move it from the MDR into the MAR (gate_mdr with ld_mar) before the second access.
- R8: The call instruction first writes the PC into register 7 (gate_pc, ld_reg, dr_sel=1). If ir_cond[2]=1 it then loads the PC from PC+offset11 (addr2_sel=11). Otherwise it loads the PC from the base register (addr1_sel=1, sr1_sel=1, addr2_sel=00).
- R9: The summed load puts the ALU sum onto the bus into the MAR (alu_op=00, sr1_sel=1, sr2_sel=0 whatever ir_imm_sel is). It then reads and writes the data with ld_reg and ld_cc.
- R10: lea writes PC+offset9 from the address path into the register without ld_cc. jmp loads the PC from the base register with pc_sel=01, addr1_sel=1, addr2_sel=00.
- R11: After the halt opcode the sequencer stays in the halt state with all controls 0 until reset.
- R12: ld_cc is asserted only together with ld_reg, and only for add, and, not, ld, ldr, ldi and the summed load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_opcode | input | 4 | Instruction bits 15:12 |
| ir_imm_sel | input | 1 | Instruction bit 5, register/immediate select |
| ir_cond | input | 3 | Instruction bits 11:9 (branch mask, call form in bit 2) |
| cc_n | input | 1 | Negative flag |
| cc_z | input | 1 | Zero flag |
| cc_p | input | 1 | Positive flag |
| ld_mar | output | 1 | Load memory address register |
| ld_mdr | output | 1 | Load memory data register |
| ld_ir | output | 1 | Load instruction register |
| ld_reg | output | 1 | Write register file |
| ld_cc | output | 1 | Load condition flags |
| ld_pc | output | 1 | Load program counter |
| gate_pc | output | 1 | Drive PC onto bus |
| gate_mdr | output | 1 | Drive MDR onto bus |
| gate_alu | output | 1 | Drive ALU onto bus |
| gate_marmux | output | 1 | Drive address path onto bus |
| pc_sel | output | 2 | PC source: 00 increment, 01 address adder, 10 bus |
| dr_sel | output | 1 | Destination: 0 bits 11:9, 1 register 7 |
| sr1_sel | output | 1 | Source 1: 0 bits 11:9, 1 bits 8:6 |
| addr1_sel | output | 1 | Adder base: 0 PC, 1 source register |
| addr2_sel | output | 2 | Adder offset: 00 zero, 01 off6, 10 off9, 11 off11 |
| mar_sel | output | 1 | Address path: 0 zero-extended byte, 1 adder |
| alu_op | output | 2 | 00 add, 01 and, 10 not, 11 pass |
| sr2_sel | output | 1 | ALU second operand: 0 register, 1 immediate |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |

## Verification
The two functions that share a single cycle here are the register write and the flag load. The same holds for the call sequence, where register 7 is written in the cycle that precedes the choice between the two target forms. Both are provoked by issuing add, and, not, the three loads and the summed load, then call with ir_cond[2] set and cleared. Each cycle's full control word is judged against a scoreboard entry. The bench also drives ir_imm_sel high during a summed load and while branches not taken fall through. That shows the operand select leaks into no cycle except add and and.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UADDR_W = 6;
    localparam int OPC_W   = 4;
    localparam int COND_W  = 3;

    typedef logic [UADDR_W-1:0] uaddr_t;

    typedef enum logic [1:0] {
        SQ_JUMP     = 2'd0,
        SQ_DISPATCH = 2'd1,
        SQ_BRANCH   = 2'd2,
        SQ_LINK     = 2'd3
    } seq_mode_e;

    typedef struct packed {
        logic       ld_mar;
        logic       ld_mdr;
        logic       ld_ir;
        logic       ld_reg;
        logic       ld_cc;
        logic       ld_pc;
        logic       gate_pc;
        logic       gate_mdr;
        logic       gate_alu;
        logic       gate_marmux;
        logic [1:0] pc_sel;
        logic       dr_sel;
        logic       sr1_sel;
        logic       addr1_sel;
        logic [1:0] addr2_sel;
        logic       mar_sel;
        logic [1:0] alu_op;
        logic       sr2_ir;
        logic       mem_en;
        logic       mem_we;
    } dp_ctrl_t;

    typedef struct packed {
        seq_mode_e mode;
        uaddr_t    target;
        dp_ctrl_t  ctl;
    } uword_t;

    localparam logic [1:0] PCS_INC  = 2'b00;
    localparam logic [1:0] PCS_ADDR = 2'b01;
    localparam logic [1:0] PCS_BUS  = 2'b10;

    localparam logic [1:0] A2_ZERO  = 2'b00;
    localparam logic [1:0] A2_OFF6  = 2'b01;
    localparam logic [1:0] A2_OFF9  = 2'b10;
    localparam logic [1:0] A2_OFF11 = 2'b11;

    localparam logic [1:0] ALU_ADD  = 2'b00;
    localparam logic [1:0] ALU_AND  = 2'b01;
    localparam logic [1:0] ALU_NOT  = 2'b10;
    localparam logic [1:0] ALU_PASS = 2'b11;

    // micro-addresses
    localparam uaddr_t S_F0    = 6'd0;
    localparam uaddr_t S_F1    = 6'd1;
    localparam uaddr_t S_F2    = 6'd2;
    localparam uaddr_t S_ADD   = 6'd3;
    localparam uaddr_t S_AND   = 6'd4;
    localparam uaddr_t S_NOT   = 6'd5;
    localparam uaddr_t S_LEA   = 6'd6;
    localparam uaddr_t S_JMP   = 6'd7;
    localparam uaddr_t S_BR0   = 6'd8;
    localparam uaddr_t S_BR1   = 6'd9;
    localparam uaddr_t S_LD0   = 6'd10;
    localparam uaddr_t S_LD1   = 6'd11;
    localparam uaddr_t S_LD2   = 6'd12;
    localparam uaddr_t S_ST0   = 6'd13;
    localparam uaddr_t S_ST1   = 6'd14;
    localparam uaddr_t S_ST2   = 6'd15;
    localparam uaddr_t S_LDR0  = 6'd16;
    localparam uaddr_t S_LDR1  = 6'd17;
    localparam uaddr_t S_LDR2  = 6'd18;
    localparam uaddr_t S_STR0  = 6'd19;
    localparam uaddr_t S_STR1  = 6'd20;
    localparam uaddr_t S_STR2  = 6'd21;
    localparam uaddr_t S_LDI0  = 6'd22;
    localparam uaddr_t S_LDI1  = 6'd23;
    localparam uaddr_t S_LDI2  = 6'd24;
    localparam uaddr_t S_LDI3  = 6'd25;
    localparam uaddr_t S_LDI4  = 6'd26;
    localparam uaddr_t S_STI0  = 6'd27;
    localparam uaddr_t S_STI1  = 6'd28;
    localparam uaddr_t S_STI2  = 6'd29;
    localparam uaddr_t S_STI3  = 6'd30;
    localparam uaddr_t S_STI4  = 6'd31;
    localparam uaddr_t S_CALL0 = 6'd32;
    localparam uaddr_t S_CALLO = 6'd33;  // offset form, must precede base form
    localparam uaddr_t S_CALLB = 6'd34;
    localparam uaddr_t S_SUM0  = 6'd35;
    localparam uaddr_t S_SUM1  = 6'd36;
    localparam uaddr_t S_SUM2  = 6'd37;
    localparam uaddr_t S_HALT  = 6'd38;

    // building blocks of the control store
    function automatic dp_ctrl_t c_mem_read();
        dp_ctrl_t c = '0;
        c.ld_mdr = 1'b1;
        c.mem_en = 1'b1;
        return c;
    endfunction

    function automatic dp_ctrl_t c_mem_write();
        dp_ctrl_t c = '0;
        c.mem_en = 1'b1;
        c.mem_we = 1'b1;
        return c;
    endfunction

    function automatic dp_ctrl_t c_load_result();
        dp_ctrl_t c = '0;
        c.gate_mdr = 1'b1;
        c.ld_reg   = 1'b1;
        c.ld_cc    = 1'b1;
        return c;
    endfunction

    function automatic dp_ctrl_t c_mar_from_adder(input logic base_reg,
                                                  input logic [1:0] off);
        dp_ctrl_t c = '0;
        c.ld_mar      = 1'b1;
        c.gate_marmux = 1'b1;
        c.mar_sel     = 1'b1;
        c.addr1_sel   = base_reg;
        c.sr1_sel     = base_reg;
        c.addr2_sel   = off;
        return c;
    endfunction

    function automatic dp_ctrl_t c_mar_from_mdr();
        dp_ctrl_t c = '0;
        c.gate_mdr = 1'b1;
        c.ld_mar   = 1'b1;
        return c;
    endfunction

    function automatic dp_ctrl_t c_mdr_from_src();
        dp_ctrl_t c = '0;
        c.gate_alu = 1'b1;
        c.alu_op   = ALU_PASS;
        c.sr1_sel  = 1'b0;
        c.ld_mdr   = 1'b1;
        return c;
    endfunction

    function automatic dp_ctrl_t c_alu_write(input logic [1:0] op, input logic use_imm);
        dp_ctrl_t c = '0;
        c.gate_alu = 1'b1;
        c.ld_reg   = 1'b1;
        c.ld_cc    = 1'b1;
        c.sr1_sel  = 1'b1;
        c.alu_op   = op;
        c.sr2_ir   = use_imm;
        return c;
    endfunction

    function automatic dp_ctrl_t c_pc_from_adder(input logic base_reg,
                                                 input logic [1:0] off);
        dp_ctrl_t c = '0;
        c.ld_pc     = 1'b1;
        c.pc_sel    = PCS_ADDR;
        c.addr1_sel = base_reg;
        c.sr1_sel   = base_reg;
        c.addr2_sel = off;
        return c;
    endfunction

    // one control-store word; unused addresses are quiet and return to fetch
    function automatic uword_t ucode_entry(input uaddr_t a);
        uword_t w;
        w        = '0;
        w.mode   = SQ_JUMP;
        w.target = S_F0;
        case (a)
            S_F0: begin
                w.ctl.gate_pc = 1'b1;
                w.ctl.ld_mar  = 1'b1;
                w.ctl.ld_pc   = 1'b1;
                w.ctl.pc_sel  = PCS_INC;
                w.target      = S_F1;
            end
            S_F1: begin
                w.ctl    = c_mem_read();
                w.target = S_F2;
            end
            S_F2: begin
                w.ctl.gate_mdr = 1'b1;
                w.ctl.ld_ir    = 1'b1;
                w.mode         = SQ_DISPATCH;
            end
            S_ADD: w.ctl = c_alu_write(ALU_ADD, 1'b1);
            S_AND: w.ctl = c_alu_write(ALU_AND, 1'b1);
            S_NOT: w.ctl = c_alu_write(ALU_NOT, 1'b0);
            S_LEA: begin
                w.ctl.gate_marmux = 1'b1;
                w.ctl.mar_sel     = 1'b1;
                w.ctl.addr2_sel   = A2_OFF9;
                w.ctl.ld_reg      = 1'b1;
            end
            S_JMP: w.ctl = c_pc_from_adder(1'b1, A2_ZERO);
            S_BR0: begin
                w.mode   = SQ_BRANCH;
                w.target = S_BR1;
            end
            S_BR1: w.ctl = c_pc_from_adder(1'b0, A2_OFF9);
            S_LD0: begin w.ctl = c_mar_from_adder(1'b0, A2_OFF9); w.target = S_LD1; end
            S_LD1: begin w.ctl = c_mem_read();                    w.target = S_LD2; end
            S_LD2: w.ctl = c_load_result();
            S_ST0: begin w.ctl = c_mar_from_adder(1'b0, A2_OFF9); w.target = S_ST1; end
            S_ST1: begin w.ctl = c_mdr_from_src();                w.target = S_ST2; end
            S_ST2: w.ctl = c_mem_write();
            S_LDR0: begin w.ctl = c_mar_from_adder(1'b1, A2_OFF6); w.target = S_LDR1; end
            S_LDR1: begin w.ctl = c_mem_read();                    w.target = S_LDR2; end
            S_LDR2: w.ctl = c_load_result();
            S_STR0: begin w.ctl = c_mar_from_adder(1'b1, A2_OFF6); w.target = S_STR1; end
            S_STR1: begin w.ctl = c_mdr_from_src();                w.target = S_STR2; end
            S_STR2: w.ctl = c_mem_write();
            S_LDI0: begin w.ctl = c_mar_from_adder(1'b0, A2_OFF9); w.target = S_LDI1; end
            S_LDI1: begin w.ctl = c_mem_read();                    w.target = S_LDI2; end
            S_LDI2: begin w.ctl = c_mar_from_mdr();                w.target = S_LDI3; end
            S_LDI3: begin w.ctl = c_mem_read();                    w.target = S_LDI4; end
            S_LDI4: w.ctl = c_load_result();
            S_STI0: begin w.ctl = c_mar_from_adder(1'b0, A2_OFF9); w.target = S_STI1; end
            S_STI1: begin w.ctl = c_mem_read();                    w.target = S_STI2; end
            S_STI2: begin w.ctl = c_mar_from_mdr();                w.target = S_STI3; end
            S_STI3: begin w.ctl = c_mdr_from_src();                w.target = S_STI4; end
            S_STI4: w.ctl = c_mem_write();
            S_CALL0: begin
                w.ctl.gate_pc = 1'b1;
                w.ctl.ld_reg  = 1'b1;
                w.ctl.dr_sel  = 1'b1;
                w.mode        = SQ_LINK;
                w.target      = S_CALLO;
            end
            S_CALLO: w.ctl = c_pc_from_adder(1'b0, A2_OFF11);
            S_CALLB: w.ctl = c_pc_from_adder(1'b1, A2_ZERO);
            S_SUM0: begin
                w.ctl.gate_alu = 1'b1;
                w.ctl.alu_op   = ALU_ADD;
                w.ctl.sr1_sel  = 1'b1;
                w.ctl.ld_mar   = 1'b1;
                w.target       = S_SUM1;
            end
            S_SUM1: begin w.ctl = c_mem_read(); w.target = S_SUM2; end
            S_SUM2: w.ctl = c_load_result();
            S_HALT: w.target = S_HALT;
            default: ;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int ADDR_W = UADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output uword_t            word
);

    localparam int DEPTH = 1 << ADDR_W;

    uword_t store_tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign store_tbl[i] = ucode_entry(uaddr_t'(i));
    end

    assign word = store_tbl[addr];

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int OP_W = OPC_W,
    parameter int CW   = COND_W
) (
    input  seq_mode_e       mode,
    input  uaddr_t          target,
    input  logic [OP_W-1:0] opcode,
    input  logic [CW-1:0]   cond,
    input  logic            flag_n,
    input  logic            flag_z,
    input  logic            flag_p,
    output uaddr_t          upc_next
);

    function automatic uaddr_t dispatch(input logic [OP_W-1:0] op);
        uaddr_t d;
        case (op)
            4'b0000: d = S_BR0;
            4'b0001: d = S_ADD;
            4'b0010: d = S_LD0;
            4'b0011: d = S_ST0;
            4'b0100: d = S_CALL0;
            4'b0101: d = S_AND;
            4'b0110: d = S_LDR0;
            4'b0111: d = S_STR0;
            4'b1001: d = S_NOT;
            4'b1010: d = S_LDI0;
            4'b1011: d = S_STI0;
            4'b1100: d = S_JMP;
            4'b1101: d = S_SUM0;
            4'b1110: d = S_LEA;
            4'b1111: d = S_HALT;
            default: d = S_F0;
        endcase
        return d;
    endfunction

    logic taken;
    assign taken = (cond[2] & flag_n) | (cond[1] & flag_z) | (cond[0] & flag_p);

    always_comb begin
        case (mode)
            SQ_DISPATCH: upc_next = dispatch(opcode);
            SQ_BRANCH:   upc_next = taken ? target : S_F0;
            SQ_LINK:     upc_next = cond[2] ? target : uaddr_t'(target + 1'b1);
            default:     upc_next = target;
        endcase
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int STATE_W = UADDR_W,
    parameter int OP_W    = OPC_W,
    parameter int CW      = COND_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] ir_opcode,
    input  logic            ir_imm_sel,
    input  logic [CW-1:0]   ir_cond,
    input  logic            cc_n,
    input  logic            cc_z,
    input  logic            cc_p,
    output logic            ld_mar,
    output logic            ld_mdr,
    output logic            ld_ir,
    output logic            ld_reg,
    output logic            ld_cc,
    output logic            ld_pc,
    output logic            gate_pc,
    output logic            gate_mdr,
    output logic            gate_alu,
    output logic            gate_marmux,
    output logic [1:0]      pc_sel,
    output logic            dr_sel,
    output logic            sr1_sel,
    output logic            addr1_sel,
    output logic [1:0]      addr2_sel,
    output logic            mar_sel,
    output logic [1:0]      alu_op,
    output logic            sr2_sel,
    output logic            mem_en,
    output logic            mem_we
);

    typedef struct packed {
        logic [STATE_W-1:0] upc;
    } seq_regs_t;

    seq_regs_t st_d, st_q;
    uword_t    word;
    uaddr_t    upc_next;
    dp_ctrl_t  ctl;

    useq_store #(.ADDR_W(STATE_W)) u_store (
        .addr (st_q.upc),
        .word (word)
    );

    useq_next #(.OP_W(OP_W), .CW(CW)) u_next (
        .mode     (word.mode),
        .target   (word.target),
        .opcode   (ir_opcode),
        .cond     (ir_cond),
        .flag_n   (cc_n),
        .flag_z   (cc_z),
        .flag_p   (cc_p),
        .upc_next (upc_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upc = upc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{upc: S_F0};
        else        st_q <= st_d;
    end

    // controls are held quiet while reset is applied
    assign ctl = rst_n ? word.ctl : '0;

    assign ld_mar      = ctl.ld_mar;
    assign ld_mdr      = ctl.ld_mdr;
    assign ld_ir       = ctl.ld_ir;
    assign ld_reg      = ctl.ld_reg;
    assign ld_cc       = ctl.ld_cc;
    assign ld_pc       = ctl.ld_pc;
    assign gate_pc     = ctl.gate_pc;
    assign gate_mdr    = ctl.gate_mdr;
    assign gate_alu    = ctl.gate_alu;
    assign gate_marmux = ctl.gate_marmux;
    assign pc_sel      = ctl.pc_sel;
    assign dr_sel      = ctl.dr_sel;
    assign sr1_sel     = ctl.sr1_sel;
    assign addr1_sel   = ctl.addr1_sel;
    assign addr2_sel   = ctl.addr2_sel;
    assign mar_sel     = ctl.mar_sel;
    assign alu_op      = ctl.alu_op;
    assign sr2_sel     = ctl.sr2_ir & ir_imm_sel;
    assign mem_en      = ctl.mem_en;
    assign mem_we      = ctl.mem_we;

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
    import useq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ld_mar,
    input logic       ld_mdr,
    input logic       ld_ir,
    input logic       ld_reg,
    input logic       ld_cc,
    input logic       ld_pc,
    input logic       gate_pc,
    input logic       gate_mdr,
    input logic       gate_alu,
    input logic       gate_marmux,
    input logic [1:0] pc_sel,
    input logic       mem_en,
    input logic       mem_we,
    input uaddr_t     upc
);

    // R12: flags only move with a register write
    a_r12_cc_with_reg: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cc |-> ld_reg);

    // R3: never two bus drivers at once
    a_r3_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gate_pc, gate_mdr, gate_alu, gate_marmux}));

    // R6: a write is always an access
    a_r6_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    // R2: instruction register loads right after a memory read into the MDR
    a_r2_ir_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ir |-> ($past(mem_en) && $past(ld_mdr) && !$past(mem_we)));

    // R7: pointer moves to MAR only after it was read
    a_r7_ptr_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mar && gate_mdr) |-> ($past(mem_en) && !$past(mem_we)));

    // R5: PC never loaded with the unused select code
    a_r5_pc_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pc |-> (pc_sel != 2'b11));

    // R11: halt is sticky and quiet
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == S_HALT) |=> (upc == S_HALT));

    a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == S_HALT) |-> !(ld_mar | ld_mdr | ld_ir | ld_reg | ld_pc | mem_en));

endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_mar      (ld_mar),
    .ld_mdr      (ld_mdr),
    .ld_ir       (ld_ir),
    .ld_reg      (ld_reg),
    .ld_cc       (ld_cc),
    .ld_pc       (ld_pc),
    .gate_pc     (gate_pc),
    .gate_mdr    (gate_mdr),
    .gate_alu    (gate_alu),
    .gate_marmux (gate_marmux),
    .pc_sel      (pc_sel),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .upc         (st_q.upc)
);

// File: tb/tb_useq_ctrl.sv
`timescale 1ns/1ps
module tb_useq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ir_opcode = '0;
    logic       ir_imm_sel = 1'b0;
    logic [2:0] ir_cond = '0;
    logic       cc_n = 1'b0, cc_z = 1'b0, cc_p = 1'b0;

    logic ld_mar, ld_mdr, ld_ir, ld_reg, ld_cc, ld_pc;
    logic gate_pc, gate_mdr, gate_alu, gate_marmux;
    logic [1:0] pc_sel, addr2_sel, alu_op;
    logic dr_sel, sr1_sel, addr1_sel, mar_sel, sr2_sel, mem_en, mem_we;

    always #2 clk = ~clk;  // 250 MHz

    useq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .ir_imm_sel(ir_imm_sel),
        .ir_cond(ir_cond), .cc_n(cc_n), .cc_z(cc_z), .cc_p(cc_p),
        .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_ir(ld_ir), .ld_reg(ld_reg),
        .ld_cc(ld_cc), .ld_pc(ld_pc), .gate_pc(gate_pc), .gate_mdr(gate_mdr),
        .gate_alu(gate_alu), .gate_marmux(gate_marmux), .pc_sel(pc_sel),
        .dr_sel(dr_sel), .sr1_sel(sr1_sel), .addr1_sel(addr1_sel),
        .addr2_sel(addr2_sel), .mar_sel(mar_sel), .alu_op(alu_op),
        .sr2_sel(sr2_sel), .mem_en(mem_en), .mem_we(mem_we)
    );

    logic [22:0] obs;
    assign obs = {ld_mar, ld_mdr, ld_ir, ld_reg, ld_cc, ld_pc, gate_pc, gate_mdr,
                  gate_alu, gate_marmux, pc_sel, dr_sel, sr1_sel, addr1_sel,
                  addr2_sel, mar_sel, alu_op, sr2_sel, mem_en, mem_we};

    localparam logic [22:0] LMAR = 23'(1) << 22;
    localparam logic [22:0] LMDR = 23'(1) << 21;
    localparam logic [22:0] LIR  = 23'(1) << 20;
    localparam logic [22:0] LREG = 23'(1) << 19;
    localparam logic [22:0] LCC  = 23'(1) << 18;
    localparam logic [22:0] LPC  = 23'(1) << 17;
    localparam logic [22:0] GPC  = 23'(1) << 16;
    localparam logic [22:0] GMDR = 23'(1) << 15;
    localparam logic [22:0] GALU = 23'(1) << 14;
    localparam logic [22:0] GMMX = 23'(1) << 13;
    localparam logic [22:0] PCAD = 23'(1) << 11;
    localparam logic [22:0] DR7  = 23'(1) << 10;
    localparam logic [22:0] SR1  = 23'(1) << 9;
    localparam logic [22:0] A1R  = 23'(1) << 8;
    localparam logic [22:0] O6   = 23'(1) << 6;
    localparam logic [22:0] O9   = 23'(2) << 6;
    localparam logic [22:0] O11  = 23'(3) << 6;
    localparam logic [22:0] MSEL = 23'(1) << 5;
    localparam logic [22:0] AAND = 23'(1) << 3;
    localparam logic [22:0] ANOT = 23'(2) << 3;
    localparam logic [22:0] APAS = 23'(3) << 3;
    localparam logic [22:0] SR2I = 23'(1) << 2;
    localparam logic [22:0] MEN  = 23'(1) << 1;
    localparam logic [22:0] MWE  = 23'(1);

    localparam logic [22:0] RD     = LMDR | MEN;
    localparam logic [22:0] WB     = GMDR | LREG | LCC;
    localparam logic [22:0] PC9    = LMAR | GMMX | MSEL | O9;
    localparam logic [22:0] BASE6  = LMAR | GMMX | MSEL | SR1 | A1R | O6;
    localparam logic [22:0] PASS   = LMDR | GALU | APAS;
    localparam logic [22:0] WR     = MEN | MWE;

    logic [22:0] exp_q [$];
    string       tag_q [$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic push(input logic [22:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // driver: called at posedge+1 of a fetch cycle
    task automatic issue(input logic [3:0] op, input logic imm, input logic [2:0] cnd,
                         input logic n, input logic z, input logic p, input string t);
        int len;
        ir_opcode = op; ir_imm_sel = imm; ir_cond = cnd; cc_n = n; cc_z = z; cc_p = p;
        push(LMAR | LPC | GPC, {"R2 fetch0 ", t});
        push(RD,               {"R2 fetch1 ", t});
        push(GMDR | LIR,       {"R2 fetch2 ", t});
        len = 3;
        case (op)
            4'b0001: begin push(LREG | LCC | GALU | SR1 | (imm ? SR2I : 23'd0), {"R4 add ", t}); len += 1; end
            4'b0101: begin push(LREG | LCC | GALU | SR1 | AAND | (imm ? SR2I : 23'd0), {"R4 and ", t}); len += 1; end
            4'b1001: begin push(LREG | LCC | GALU | SR1 | ANOT, {"R4 not ", t}); len += 1; end
            4'b1110: begin push(LREG | GMMX | MSEL | O9, {"R10 lea ", t}); len += 1; end
            4'b1100: begin push(LPC | PCAD | SR1 | A1R, {"R10 jmp ", t}); len += 1; end
            4'b0000: begin
                push('0, {"R5 decide ", t}); len += 1;
                if ((cnd[2] & n) | (cnd[1] & z) | (cnd[0] & p)) begin
                    push(LPC | PCAD | O9, {"R5 taken ", t}); len += 1;
                end
            end
            4'b0010: begin push(PC9, {"R6 ld a ", t}); push(RD, {"R6 ld r ", t}); push(WB, {"R12 ld wb ", t}); len += 3; end
            4'b0011: begin push(PC9, {"R6 st a ", t}); push(PASS, {"R6 st d ", t}); push(WR, {"R6 st w ", t}); len += 3; end
            4'b0110: begin push(BASE6, {"R6 ldr a ", t}); push(RD, {"R6 ldr r ", t}); push(WB, {"R12 ldr wb ", t}); len += 3; end
            4'b0111: begin push(BASE6, {"R6 str a ", t}); push(PASS, {"R6 str d ", t}); push(WR, {"R6 str w ", t}); len += 3; end
            4'b1010: begin
                push(PC9, {"R7 ldi a ", t}); push(RD, {"R7 ldi r1 ", t});
                push(GMDR | LMAR, {"R7 ldi ptr ", t}); push(RD, {"R7 ldi r2 ", t});
                push(WB, {"R7 ldi wb ", t}); len += 5;
            end
            4'b1011: begin
                push(PC9, {"R7 sti a ", t}); push(RD, {"R7 sti r ", t});
                push(GMDR | LMAR, {"R7 sti ptr ", t}); push(PASS, {"R7 sti d ", t});
                push(WR, {"R7 sti w ", t}); len += 5;
            end
            4'b0100: begin
                push(GPC | LREG | DR7, {"R8 link ", t});
                if (cnd[2]) push(LPC | PCAD | O11, {"R8 off11 ", t});
                else        push(LPC | PCAD | SR1 | A1R, {"R8 base ", t});
                len += 2;
            end
            4'b1101: begin
                push(GALU | LMAR | SR1, {"R9 sum addr ", t}); push(RD, {"R9 sum r ", t});
                push(WB, {"R9 sum wb ", t}); len += 3;
            end
            4'b1111: begin
                for (int i = 0; i < 6; i++) push('0, {"R11 halt ", t});
                len += 6;
            end
            default: ; // R3: opcode 1000 goes straight back to fetch
        endcase
        repeat (len) @(posedge clk);
        #1;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [22:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (obs !== e) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", t, obs, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check_reset_quiet(input string t);
        @(negedge clk);
        checks++;
        if (obs !== '0) begin
            fails++;
            $display("FAIL %s: got %h expected %h", t, obs, 23'd0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        check_reset_quiet("R1 reset quiet");
        @(posedge clk); #1;
        rst_n = 1'b1;
        issue(4'b0001, 1'b0, 3'b000, 0, 0, 0, "add reg");
        issue(4'b0001, 1'b1, 3'b000, 0, 0, 0, "add imm");
        issue(4'b0101, 1'b1, 3'b000, 0, 0, 0, "and imm");
        issue(4'b0101, 1'b0, 3'b000, 0, 0, 0, "and reg");
        issue(4'b1001, 1'b1, 3'b000, 0, 0, 0, "not");
        issue(4'b1110, 1'b1, 3'b000, 0, 0, 0, "lea");
        issue(4'b1100, 1'b0, 3'b000, 0, 0, 0, "jmp");
        issue(4'b0000, 1'b1, 3'b100, 1, 0, 0, "br n taken");
        issue(4'b0000, 1'b1, 3'b010, 1, 0, 0, "br z untaken");
        issue(4'b0000, 1'b0, 3'b001, 0, 0, 1, "br p taken");
        issue(4'b0000, 1'b0, 3'b000, 1, 1, 1, "br none");
        issue(4'b0000, 1'b0, 3'b111, 0, 1, 0, "br all");
        issue(4'b0010, 1'b0, 3'b000, 0, 0, 0, "ld");
        issue(4'b0011, 1'b1, 3'b000, 0, 0, 0, "st");
        issue(4'b0110, 1'b0, 3'b000, 0, 0, 0, "ldr");
        issue(4'b0111, 1'b0, 3'b000, 0, 0, 0, "str");
        issue(4'b1010, 1'b0, 3'b000, 0, 0, 0, "ldi");
        issue(4'b1011, 1'b0, 3'b000, 0, 0, 0, "sti");
        issue(4'b0100, 1'b0, 3'b100, 0, 0, 0, "call off");
        issue(4'b0100, 1'b0, 3'b011, 0, 0, 0, "call base");
        issue(4'b1101, 1'b1, 3'b000, 0, 0, 0, "sum imm high");
        issue(4'b1000, 1'b0, 3'b000, 0, 0, 0, "R3 unused op");
        issue(4'b0001, 1'b1, 3'b000, 0, 0, 0, "add after unused");
        issue(4'b1111, 1'b0, 3'b000, 0, 0, 0, "halt");
        // R1: reset out of halt restarts at fetch
        rst_n = 1'b0;
        check_reset_quiet("R1 reset in halt");
        @(posedge clk); #1;
        rst_n = 1'b1;
        issue(4'b1001, 1'b0, 3'b000, 0, 0, 0, "R1 restart not");
        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule